// File: doc/BRIEF.md
# Masked-Compare Waveform Output Stage

This block turns the value of an external down counter into two output waveforms. The first is a pulse-width output. It reacts to two masked comparisons made whenever the counter advances. One compares the counter with zero. The other compares the counter with a compare register. Both sides are ANDed with a shared mask before matching, so the mask sets the waveform period and the compare value sets the duty point. The pulse-width output can hold a static level, run in set/reset mode with a selectable polarity, or toggle on every compare hit.

The second output is an overflow output, driven by the counter's wrap strobe. In latch mode each wrap raises a sticky flag, and the pin follows that flag until software clears it with a one-cycle clear strobe. In toggle mode each wrap inverts the pin, which gives a square wave at half the wrap rate. The counter, its reload value and its prescaler sit outside the block. The block only sees the counter value, a tick that marks each counter update, and the wrap strobe.

Top module: `mcmp_wavegen`

## Requirements
- R1: A compare hit occurs when `(mask_i & count_i) == (mask_i & cmp_i)`, and a zero hit occurs when `(mask_i & count_i) == 0`. Bits where `mask_i` is 0 do not affect either hit.
- R2: While `pwm_en_i` is 0, `pwm_o` takes the value of `pwm_pol_i` at the clock edge that samples it.
- R3: With `pwm_en_i`=1, `pwm_toggle_i`=0 and `pwm_pol_i`=1, a zero hit on a tick sets `pwm_o` to 1 and a compare hit on a tick clears it to 0, one clock after the tick.
- R4: With `pwm_en_i`=1, `pwm_toggle_i`=0 and `pwm_pol_i`=0, a zero hit on a tick clears `pwm_o` and a compare hit on a tick sets it.
- R5: In set/reset mode, when a zero hit and a compare hit fall on the same tick, the compare hit decides the level (`pwm_o` = NOT `pwm_pol_i`).
- R6: With `pwm_en_i`=1 and `pwm_toggle_i`=1, every compare hit on a tick inverts `pwm_o`. Zero hits and `pwm_pol_i` have no effect.
- R7: Hits are acted on only in a cycle where `tick_i` is 1. A counter that holds a matching value without a tick leaves `pwm_o` unchanged.
- R8: With the counter stepping down once per tick, a mask whose highest set bit is n gives a set/reset period of 2^(n+1) ticks and a toggle period of twice that. A full 16-bit mask with no reload gives 2^16 ticks.
- R9: With `ovf_toggle_i`=0, a wrap strobe sets `ovf_flag_o` and `ovf_o` to 1. Both stay 1 until `flag_clr_i` returns both to 0.
- R10: With `ovf_toggle_i`=1, each wrap strobe inverts `ovf_o` and also sets `ovf_flag_o`.
- R11: When a wrap strobe and `flag_clr_i` arrive in the same cycle, the flag ends up set.
- R12: After reset, `pwm_o`, `ovf_o` and `ovf_flag_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | High in each cycle where `count_i` holds a freshly updated value |
| count_i | input | CNT_W | Current counter value |
| ovf_i | input | 1 | One-cycle counter wrap strobe |
| cmp_i | input | CNT_W | Compare value |
| mask_i | input | CNT_W | AND-mask applied to both counter and compare value |
| pwm_en_i | input | 1 | Enables waveform generation on `pwm_o` |
| pwm_toggle_i | input | 1 | 1: toggle mode, 0: set/reset mode |
| pwm_pol_i | input | 1 | Polarity, or static level when disabled |
| ovf_toggle_i | input | 1 | 1: overflow pin toggles, 0: overflow pin latches |
| flag_clr_i | input | 1 | One-cycle clear of the overflow flag |
| pwm_o | output | 1 | Pulse-width output pin |
| ovf_o | output | 1 | Overflow output pin |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with the default width, CNT_W = 16. This makes the unmasked case reachable: one full 65536-tick counter sweep is run, and it must produce exactly one rising and one falling pulse edge with a high time of 32768 ticks. Narrow masks with their top set bit at position 3 shrink the period to 16 or 32 ticks, which allows duty and toggle counts over several periods. Direct single-tick stimulus reaches the corner cases: coincident hits, masked-off bits, stalled ticks, and a clear that collides with a wrap.

// File: rtl/mcmp_pkg.sv
package mcmp_pkg;

    typedef enum logic [1:0] {
        PWM_STATIC = 2'd0,
        PWM_SETRST = 2'd1,
        PWM_TOGGLE = 2'd2
    } pwm_mode_e;

    typedef struct packed {
        logic pin;
    } pwm_state_t;

    typedef struct packed {
        logic pin;
        logic flag;
    } ovf_state_t;

    function automatic pwm_mode_e decode_pwm_mode(input logic en, input logic toggle);
        if (!en) begin
            return PWM_STATIC;
        end
        return toggle ? PWM_TOGGLE : PWM_SETRST;
    endfunction

endpackage

// File: rtl/mcmp_match.sv
module mcmp_match #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic [CNT_W-1:0] mask_i,
    output logic             zero_hit_o,
    output logic             cmp_hit_o
);

    logic [CNT_W-1:0] zero_bits;
    logic [CNT_W-1:0] diff_bits;

    // Per-bit masked terms; a set bit marks a mismatch in a kept position
    for (genvar b = 0; b < CNT_W; b++) begin : g_bit
        assign zero_bits[b] = mask_i[b] & count_i[b];
        assign diff_bits[b] = mask_i[b] & (count_i[b] ^ cmp_i[b]);
    end

    assign zero_hit_o = ~|zero_bits;
    assign cmp_hit_o  = ~|diff_bits;

endmodule

// File: rtl/mcmp_pwm_stage.sv
module mcmp_pwm_stage
    import mcmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic zero_hit_i,
    input  logic cmp_hit_i,
    input  logic en_i,
    input  logic toggle_i,
    input  logic pol_i,
    output logic pin_o
);

    pwm_state_t st_q;
    pwm_state_t st_d;
    pwm_mode_e  mode;

    assign mode = decode_pwm_mode(en_i, toggle_i);

    always_comb begin
        st_d = st_q;
        unique case (mode)
            PWM_STATIC: begin
                st_d.pin = pol_i;
            end
            PWM_SETRST: begin
                if (tick_i) begin
                    // compare hit takes priority over zero hit
                    if (cmp_hit_i) begin
                        st_d.pin = ~pol_i;
                    end else if (zero_hit_i) begin
                        st_d.pin = pol_i;
                    end
                end
            end
            PWM_TOGGLE: begin
                if (tick_i && cmp_hit_i) begin
                    st_d.pin = ~st_q.pin;
                end
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_o = st_q.pin;

    AST_STATIC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> pin_o == $past(pol_i)); // R2

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !tick_i) |=> $stable(pin_o)); // R7

    AST_CMP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !toggle_i && tick_i && cmp_hit_i) |=> pin_o == !$past(pol_i)); // R5

    AST_ZERO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !toggle_i && tick_i && zero_hit_i && !cmp_hit_i) |=> pin_o == $past(pol_i)); // R3

    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && toggle_i && tick_i && cmp_hit_i) |=> pin_o != $past(pin_o)); // R6

    AST_TOGGLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && toggle_i && !cmp_hit_i) |=> $stable(pin_o)); // R6

endmodule

// File: rtl/mcmp_ovf_stage.sv
module mcmp_ovf_stage
    import mcmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_i,
    input  logic toggle_i,
    input  logic clr_i,
    output logic pin_o,
    output logic flag_o
);

    ovf_state_t st_q;
    ovf_state_t st_d;

    always_comb begin
        st_d = st_q;
        // a wrap in the same cycle as a clear leaves the flag set
        if (ovf_i) begin
            st_d.flag = 1'b1;
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end
        if (toggle_i) begin
            if (ovf_i) begin
                st_d.pin = ~st_q.pin;
            end
        end else begin
            st_d.pin = st_d.flag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_o  = st_q.pin;
    assign flag_o = st_q.flag;

    AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_i |=> flag_o); // R11

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o); // R9

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !ovf_i) |=> !flag_o); // R9

    AST_LATCH_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!toggle_i && ovf_i) |=> pin_o); // R9

    AST_WRAP_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle_i && ovf_i) |=> pin_o != $past(pin_o)); // R10

endmodule

// File: rtl/mcmp_wavegen.sv
module mcmp_wavegen
    import mcmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             ovf_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic [CNT_W-1:0] mask_i,
    input  logic             pwm_en_i,
    input  logic             pwm_toggle_i,
    input  logic             pwm_pol_i,
    input  logic             ovf_toggle_i,
    input  logic             flag_clr_i,
    output logic             pwm_o,
    output logic             ovf_o,
    output logic             ovf_flag_o
);

    logic zero_hit;
    logic cmp_hit;

    mcmp_match #(
        .CNT_W (CNT_W)
    ) u_match (
        .count_i    (count_i),
        .cmp_i      (cmp_i),
        .mask_i     (mask_i),
        .zero_hit_o (zero_hit),
        .cmp_hit_o  (cmp_hit)
    );

    mcmp_pwm_stage u_pwm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .zero_hit_i (zero_hit),
        .cmp_hit_i  (cmp_hit),
        .en_i       (pwm_en_i),
        .toggle_i   (pwm_toggle_i),
        .pol_i      (pwm_pol_i),
        .pin_o      (pwm_o)
    );

    mcmp_ovf_stage u_ovf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovf_i    (ovf_i),
        .toggle_i (ovf_toggle_i),
        .clr_i    (flag_clr_i),
        .pin_o    (ovf_o),
        .flag_o   (ovf_flag_o)
    );

    AST_MASKED_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en_i && !pwm_toggle_i && tick_i
         && ((mask_i & count_i) == (mask_i & cmp_i))) |=> pwm_o == !$past(pwm_pol_i)); // R1

endmodule

// File: tb/mcmp_wavegen_tb_top.sv
module mcmp_wavegen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int WATCHDOG   = 190000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_i = 1'b0;
    logic [W-1:0] count_i = '0;
    logic         ovf_i = 1'b0;
    logic [W-1:0] cmp_i = '0;
    logic [W-1:0] mask_i = '1;
    logic         pwm_en_i = 1'b0;
    logic         pwm_toggle_i = 1'b0;
    logic         pwm_pol_i = 1'b0;
    logic         ovf_toggle_i = 1'b0;
    logic         flag_clr_i = 1'b0;
    logic         pwm_o;
    logic         ovf_o;
    logic         ovf_flag_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcmp_wavegen #(.CNT_W(W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .count_i      (count_i),
        .ovf_i        (ovf_i),
        .cmp_i        (cmp_i),
        .mask_i       (mask_i),
        .pwm_en_i     (pwm_en_i),
        .pwm_toggle_i (pwm_toggle_i),
        .pwm_pol_i    (pwm_pol_i),
        .ovf_toggle_i (ovf_toggle_i),
        .flag_clr_i   (flag_clr_i),
        .pwm_o        (pwm_o),
        .ovf_o        (ovf_o),
        .ovf_flag_o   (ovf_flag_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a falling edge: apply inputs, pass one rising edge, return at next falling edge
    task automatic step(input logic [W-1:0] v, input bit t, input bit o, input bit c);
        count_i    = v;
        tick_i     = t;
        ovf_i      = o;
        flag_clr_i = c;
        @(posedge clk);
        @(negedge clk);
        tick_i     = 1'b0;
        ovf_i      = 1'b0;
        flag_clr_i = 1'b0;
    endtask

    task automatic force_low();
        pwm_en_i  = 1'b0;
        pwm_pol_i = 1'b0;
        step('0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        chk("R12 pwm_o", pwm_o, 0);
        chk("R12 ovf_o", ovf_o, 0);
        chk("R12 ovf_flag_o", ovf_flag_o, 0);
    endtask

    task automatic t_static();
        pwm_en_i = 1'b0; pwm_pol_i = 1'b1;
        step(16'h0000, 1'b1, 1'b0, 1'b0);
        chk("R2 static high", pwm_o, 1);
        pwm_pol_i = 1'b0;
        step(16'h0000, 1'b1, 1'b0, 1'b0);
        chk("R2 static low", pwm_o, 0);
    endtask

    task automatic t_setrst_pos();
        force_low();
        mask_i = 16'h00FF; cmp_i = 16'hAB40;
        pwm_en_i = 1'b1; pwm_toggle_i = 1'b0; pwm_pol_i = 1'b1;
        step(16'h1200, 1'b1, 1'b0, 1'b0);
        chk("R3 zero hit sets", pwm_o, 1);
        step(16'h1241, 1'b1, 1'b0, 1'b0);
        chk("R3 no hit holds", pwm_o, 1);
        step(16'h1240, 1'b1, 1'b0, 1'b0);
        chk("R1 masked cmp hit clears (upper bits differ)", pwm_o, 0);
        step(16'h0100, 1'b1, 1'b0, 1'b0);
        chk("R1 zero hit with masked-off bit set", pwm_o, 1);
    endtask

    task automatic t_setrst_neg();
        mask_i = 16'h00FF; cmp_i = 16'h0040;
        pwm_en_i = 1'b1; pwm_toggle_i = 1'b0; pwm_pol_i = 1'b0;
        step(16'h0040, 1'b1, 1'b0, 1'b0);
        chk("R4 cmp hit sets", pwm_o, 1);
        step(16'h0000, 1'b1, 1'b0, 1'b0);
        chk("R4 zero hit clears", pwm_o, 0);
    endtask

    task automatic t_collide();
        mask_i = 16'h00F0; cmp_i = 16'h0005;
        pwm_en_i = 1'b1; pwm_toggle_i = 1'b0; pwm_pol_i = 1'b1;
        step(16'h0100, 1'b1, 1'b0, 1'b0);
        step(16'h0003, 1'b1, 1'b0, 1'b0);
        chk("R5 coincident hits pol=1", pwm_o, 0);
        pwm_pol_i = 1'b0;
        step(16'h0003, 1'b1, 1'b0, 1'b0);
        chk("R5 coincident hits pol=0", pwm_o, 1);
    endtask

    task automatic t_toggle();
        force_low();
        mask_i = 16'h00FF; cmp_i = 16'h0020;
        pwm_en_i = 1'b1; pwm_toggle_i = 1'b1; pwm_pol_i = 1'b1;
        step(16'h0000, 1'b1, 1'b0, 1'b0);
        chk("R6 zero hit ignored in toggle", pwm_o, 0);
        step(16'h0020, 1'b1, 1'b0, 1'b0);
        chk("R6 first toggle", pwm_o, 1);
        pwm_pol_i = 1'b0;
        step(16'h0120, 1'b1, 1'b0, 1'b0);
        chk("R6 second toggle pol ignored", pwm_o, 0);
    endtask

    task automatic t_no_tick();
        mask_i = 16'h00FF; cmp_i = 16'h0020;
        pwm_en_i = 1'b1; pwm_toggle_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step(16'h0020, 1'b0, 1'b0, 1'b0);
        end
        chk("R7 stalled match no toggle", pwm_o, 0);
        pwm_toggle_i = 1'b0; pwm_pol_i = 1'b1;
        step(16'h0000, 1'b0, 1'b0, 1'b0);
        chk("R7 zero without tick ignored", pwm_o, 0);
    endtask

    // Down-count sweep; returns rising, falling edges and high samples
    task automatic sweep(input logic [W-1:0] start, input int n,
                         output int rises, output int falls, output int highs);
        logic [W-1:0] v;
        logic prev;
        v = start; prev = pwm_o;
        rises = 0; falls = 0; highs = 0;
        for (int i = 0; i < n; i++) begin
            step(v, 1'b1, 1'b0, 1'b0);
            if (pwm_o && !prev) rises++;
            if (!pwm_o && prev) falls++;
            if (pwm_o) highs++;
            prev = pwm_o;
            v = v - 1'b1;
        end
    endtask

    task automatic t_period();
        int r, f, h;
        force_low();
        mask_i = 16'h000F; cmp_i = 16'h0004;
        pwm_en_i = 1'b1; pwm_toggle_i = 1'b0; pwm_pol_i = 1'b1;
        sweep(16'h0000, 64, r, f, h);
        chk("R8 setrst n=3 rises in 64", r, 4);
        chk("R8 setrst n=3 high ticks", h, 48);
        force_low();
        mask_i = 16'h000F; cmp_i = 16'h0003;
        pwm_en_i = 1'b1; pwm_toggle_i = 1'b1;
        sweep(16'h0000, 64, r, f, h);
        chk("R8 toggle n=3 rises in 64", r, 2);
        chk("R8 toggle n=3 edges in 64", r + f, 4);
        force_low();
        mask_i = 16'hFFFF; cmp_i = 16'h8000;
        pwm_en_i = 1'b1; pwm_toggle_i = 1'b0; pwm_pol_i = 1'b1;
        sweep(16'h0001, 65536, r, f, h);
        chk("R8 full mask rises", r, 1);
        chk("R8 full mask falls", f, 1);
        chk("R8 full mask high ticks", h, 32768);
    endtask

    task automatic t_ovf_latch();
        ovf_toggle_i = 1'b0;
        step(16'h0, 1'b0, 1'b1, 1'b0);
        chk("R9 wrap sets pin", ovf_o, 1);
        chk("R9 wrap sets flag", ovf_flag_o, 1);
        for (int i = 0; i < 3; i++) begin
            step(16'h0, 1'b0, 1'b0, 1'b0);
        end
        chk("R9 pin held", ovf_o, 1);
        step(16'h0, 1'b0, 1'b1, 1'b0);
        chk("R9 second wrap keeps pin", ovf_o, 1);
        step(16'h0, 1'b0, 1'b0, 1'b1);
        chk("R9 clear drops pin", ovf_o, 0);
        chk("R9 clear drops flag", ovf_flag_o, 0);
    endtask

    task automatic t_ovf_toggle();
        ovf_toggle_i = 1'b1;
        step(16'h0, 1'b0, 1'b1, 1'b0);
        chk("R10 first wrap toggles high", ovf_o, 1);
        chk("R10 flag set", ovf_flag_o, 1);
        step(16'h0, 1'b0, 1'b0, 1'b1);
        chk("R10 clear leaves toggling pin", ovf_o, 1);
        step(16'h0, 1'b0, 1'b1, 1'b0);
        chk("R10 second wrap toggles low", ovf_o, 0);
    endtask

    task automatic t_ovf_collide();
        ovf_toggle_i = 1'b0;
        step(16'h0, 1'b0, 1'b0, 1'b1);
        step(16'h0, 1'b0, 1'b1, 1'b1);
        chk("R11 wrap beats clear flag", ovf_flag_o, 1);
        chk("R11 wrap beats clear pin", ovf_o, 1);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_static();
        t_setrst_pos();
        t_setrst_neg();
        t_collide();
        t_toggle();
        t_no_tick();
        t_period();
        t_ovf_latch();
        t_ovf_toggle();
        t_ovf_collide();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) begin
            @(posedge clk);
        end
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule